// File: doc/BRIEF.md
# Power-Pulsing Sequencer for Per-Channel Converters

This controller steps a group of converter channels through a repeating four-phase power cycle: idle, analog acquisition, conversion and readout. A strobe from the system starts each cycle. At the last clock of acquisition the per-channel trigger flags are captured. Converter bias is then raised only for the channels that were flagged. Each powered channel gets a conversion permit once a fixed recovery interval has passed. The permit is withdrawn when that channel reports it is done.

Bias stays on through readout. At the end of readout the master current sources are switched off and the block returns to idle. It waits there for the next strobe, which in normal use spends most of the cycle in this state. If any triggered channel has not reported completion by the end of the conversion window, the sequencer skips readout. It cuts power at once and raises a timeout flag that holds until the next cycle starts. All durations are parameters in clock cycles.

Top module: `pulsed_bias_seq`

## Requirements
- R1: The phase output follows idle (0), acquire (1), convert (2), readout (3) and back to idle. Acquire lasts ACQ_CYC cycles, convert lasts CONV_CYC cycles and readout lasts READ_CYC cycles, counted from the clock edge that enters the phase.
- R2: A cycle-start strobe is accepted only while the phase is idle. It moves the phase to acquire on the next edge. A strobe seen in any other phase has no effect.
- R3: The trigger flags are sampled only on the final acquire clock. Trigger values at every other time are ignored, and the captured flags are cleared when a new cycle is accepted.
- R4: Bit c of the bias output is high during convert and readout exactly when channel c was captured as triggered. All bias bits are low in idle and acquire.
- R5: The conversion permit for a triggered channel rises REC_CYC cycles after its bias rises and only in the convert phase. An untriggered channel never gets a permit.
- R6: A done pulse from a channel is accepted while that channel's permit is high, and the permit falls on the next edge. Done inputs at any other time are ignored.
- R7: If any triggered channel has not been accepted as done when the convert window ends, the phase goes to idle on that edge with all bias off, skipping readout. The timeout output goes high and stays high until the next accepted start.
- R8: A synchronous active-high reset puts the phase in idle with bias, permits and timeout all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cycle_start_i | input | 1 | Strobe that begins a power cycle |
| trig_i | input | NCH | Per-channel trigger flags |
| conv_done_i | input | NCH | Per-channel conversion-complete pulses |
| bias_en_o | output | NCH | Per-channel converter bias enable |
| conv_go_o | output | NCH | Per-channel conversion-start permit |
| phase_o | output | 2 | Current phase: 0 idle, 1 acquire, 2 convert, 3 readout |
| timeout_o | output | 1 | Conversion window expired with work outstanding |

## Verification
The assertions assume that the convert window is long enough to hold the recovery wait plus at least one cycle of permit (REC_CYC < CONV_CYC). They also assume that a done pulse is only meaningful while a permit is high. The stimulus meets both conditions: it uses a small configuration with a recovery of two cycles inside an eight-cycle window, and it drives done only from the permit it has just seen. To probe the cases the design must ignore, it still drives inverted trigger values outside the sampling clock and sends extra start strobes during acquire and convert.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_READ = 2'd3
  } pps_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pps_phase_ctl.sv
module pps_phase_ctl
  import pps_pkg::*;
#(
  parameter int ACQ_CYC  = 1000,
  parameter int CONV_CYC = 500,
  parameter int READ_CYC = 500,
  parameter int REC_CYC  = 1,
  parameter int CW       = 10
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       start_i,
  input  logic       all_ok_i,
  output pps_phase_e ph_q_o,
  output logic       clr_o,
  output logic       smp_o,
  output logic       pwr_nxt_o,
  output logic       gate_nxt_o,
  output logic       tmo_q_o
);
  pps_phase_e ph_q, ph_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic tmo_q, tmo_nxt;

  always_comb begin
    ph_nxt  = ph_q;
    cnt_nxt = cnt_q + 1'b1;
    tmo_nxt = tmo_q;
    clr_o   = 1'b0;
    smp_o   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_nxt = '0;
        if (start_i) begin
          ph_nxt  = PH_ACQ;
          clr_o   = 1'b1;
          tmo_nxt = 1'b0;
        end
      end
      PH_ACQ: begin
        if (cnt_q == CW'(ACQ_CYC - 1)) begin
          smp_o   = 1'b1;
          ph_nxt  = PH_CONV;
          cnt_nxt = '0;
        end
      end
      PH_CONV: begin
        if (cnt_q == CW'(CONV_CYC - 1)) begin
          cnt_nxt = '0;
          if (all_ok_i) begin
            ph_nxt = PH_READ;
          end else begin
            ph_nxt  = PH_IDLE;
            tmo_nxt = 1'b1;
          end
        end
      end
      default: begin
        if (cnt_q == CW'(READ_CYC - 1)) begin
          ph_nxt  = PH_IDLE;
          cnt_nxt = '0;
        end
      end
    endcase
  end

  assign pwr_nxt_o  = (ph_nxt == PH_CONV) || (ph_nxt == PH_READ);
  assign gate_nxt_o = (ph_nxt == PH_CONV) && (cnt_nxt >= CW'(REC_CYC));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      cnt_q <= cnt_nxt;
      tmo_q <= tmo_nxt;
    end
  end

  assign ph_q_o  = ph_q;
  assign tmo_q_o = tmo_q;
endmodule

// File: rtl/pps_chan.sv
module pps_chan (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic smp_i,
  input  logic in_conv_i,
  input  logic pwr_nxt_i,
  input  logic gate_nxt_i,
  input  logic trig_i,
  input  logic done_i,
  output logic ok_o,
  output logic bias_o,
  output logic go_o
);
  logic trig_q, trig_nxt;
  logic done_q, done_nxt;
  logic bias_q, go_q;

  always_comb begin
    trig_nxt = clr_i ? 1'b0 : (smp_i ? trig_i : trig_q);
    done_nxt = clr_i ? 1'b0 : ((in_conv_i && go_q && done_i) ? 1'b1 : done_q);
  end

  assign ok_o = ~trig_q | done_nxt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
      bias_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      trig_q <= trig_nxt;
      done_q <= done_nxt;
      bias_q <= pwr_nxt_i & trig_nxt;
      go_q   <= gate_nxt_i & trig_nxt & ~done_nxt;
    end
  end

  assign bias_o = bias_q;
  assign go_o   = go_q;
endmodule

// File: rtl/pulsed_bias_seq.sv
module pulsed_bias_seq
  import pps_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ACQ_CYC  = 1000,
  parameter int CONV_CYC = 500,
  parameter int READ_CYC = 500,
  parameter int REC_CYC  = 1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           cycle_start_i,
  input  logic [NCH-1:0] trig_i,
  input  logic [NCH-1:0] conv_done_i,
  output logic [NCH-1:0] bias_en_o,
  output logic [NCH-1:0] conv_go_o,
  output logic [1:0]     phase_o,
  output logic           timeout_o
);
  localparam int MAXC = max3(ACQ_CYC, CONV_CYC, READ_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  pps_phase_e ph_q;
  logic clr, smp, pwr_nxt, gate_nxt, tmo_q;
  logic [NCH-1:0] ok_vec;

  pps_phase_ctl #(
    .ACQ_CYC (ACQ_CYC),
    .CONV_CYC(CONV_CYC),
    .READ_CYC(READ_CYC),
    .REC_CYC (REC_CYC),
    .CW      (CW)
  ) ctl_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (cycle_start_i),
    .all_ok_i  (&ok_vec),
    .ph_q_o    (ph_q),
    .clr_o     (clr),
    .smp_o     (smp),
    .pwr_nxt_o (pwr_nxt),
    .gate_nxt_o(gate_nxt),
    .tmo_q_o   (tmo_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pps_chan ch_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clr_i     (clr),
      .smp_i     (smp),
      .in_conv_i (ph_q == PH_CONV),
      .pwr_nxt_i (pwr_nxt),
      .gate_nxt_i(gate_nxt),
      .trig_i    (trig_i[c]),
      .done_i    (conv_done_i[c]),
      .ok_o      (ok_vec[c]),
      .bias_o    (bias_en_o[c]),
      .go_o      (conv_go_o[c])
    );
  end

  assign phase_o   = ph_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/pulsed_bias_seq_chk.sv
module pulsed_bias_seq_chk #(
  parameter int NCH     = 4,
  parameter int REC_CYC = 1
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           cycle_start_i,
  input logic [NCH-1:0] bias_en_o,
  input logic [NCH-1:0] conv_go_o,
  input logic [1:0]     phase_o,
  input logic           timeout_o
);
  logic past_ok;
  int   on_cnt;

  always_ff @(posedge clk_i) begin
    past_ok <= 1'b1;
    if (rst_i || bias_en_o == '0) on_cnt <= 0;
    else if (on_cnt < REC_CYC)    on_cnt <= on_cnt + 1;
  end

  // R1: phases only advance in order or drop to idle
  a_r1_phase_order: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && phase_o != $past(phase_o)) |->
      (phase_o == 2'($past(phase_o) + 2'd1) || phase_o == 2'd0));

  // R2: leaving idle needs a start strobe
  a_r2_start_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && $past(phase_o) == 2'd0 && phase_o == 2'd1) |-> $past(cycle_start_i));

  // R4: bias only in convert or readout
  a_r4_bias_window: assert property (@(posedge clk_i) disable iff (rst_i)
    (bias_en_o != '0) |-> phase_o[1]);

  // R5: permit only on a powered channel in convert
  a_r5_go_powered: assert property (@(posedge clk_i) disable iff (rst_i)
    (conv_go_o != '0) |-> (phase_o == 2'd2 && (conv_go_o & ~bias_en_o) == '0));

  // R5: permit only after the recovery interval
  a_r5_recovery: assert property (@(posedge clk_i) disable iff (rst_i)
    (conv_go_o != '0) |-> (on_cnt >= REC_CYC));

  // R7: timeout leaves the block idle and unpowered
  a_r7_timeout_off: assert property (@(posedge clk_i) disable iff (rst_i)
    timeout_o |-> (phase_o == 2'd0 && bias_en_o == '0));
endmodule

bind pulsed_bias_seq pulsed_bias_seq_chk #(.NCH(NCH), .REC_CYC(REC_CYC)) chk_i (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .cycle_start_i(cycle_start_i),
  .bias_en_o    (bias_en_o),
  .conv_go_o    (conv_go_o),
  .phase_o      (phase_o),
  .timeout_o    (timeout_o)
);

// File: tb/pulsed_bias_seq_tb_top.sv
`timescale 1ns/1ps
module pulsed_bias_seq_tb_top;
  localparam int NCH  = 4;
  localparam int ACQ  = 4;
  localparam int CONV = 8;
  localparam int READ = 3;
  localparam int REC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic [NCH-1:0] done = '0;
  logic [NCH-1:0] bias, go;
  logic [1:0] phase;
  logic tmo;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pulsed_bias_seq #(
    .NCH(NCH), .ACQ_CYC(ACQ), .CONV_CYC(CONV), .READ_CYC(READ), .REC_CYC(REC)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .cycle_start_i(start), .trig_i(trig),
    .conv_done_i(done), .bias_en_o(bias), .conv_go_o(go),
    .phase_o(phase), .timeout_o(tmo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // one full cycle with capture pattern tp and done-response mask rp
  task automatic run_cycle(input logic [NCH-1:0] tp, input logic [NCH-1:0] rp);
    bit ok;
    int eph, u;
    logic [NCH-1:0] ego;
    ok = ((tp & ~rp) == '0);
    @(negedge clk);
    start = 1'b1;
    trig  = ~tp;
    for (int t = 0; t <= ACQ + CONV + READ + 1; t++) begin
      @(negedge clk);
      u = t - ACQ;
      if (t < ACQ) eph = 1;
      else if (t < ACQ + CONV) eph = 2;
      else if (ok && t < ACQ + CONV + READ) eph = 3;
      else eph = 0;
      for (int c = 0; c < NCH; c++)
        ego[c] = (eph == 2) && (u >= REC) && tp[c] && !(rp[c] && u >= REC + 1);
      check("R1/R2 phase", int'(phase), eph);
      check("R3/R4 bias", int'(bias), (eph >= 2) ? int'(tp) : 0);
      check("R5/R6 permit", int'(go), int'(ego));
      check("R7 timeout", int'(tmo), (!ok && t >= ACQ + CONV) ? 1 : 0);
      // R2: extra strobes in acquire and convert must be ignored
      start = (t == 1) || (t == ACQ + 1);
      // R3: only the last acquire clock carries the real pattern
      trig  = (t == ACQ - 1) ? tp : ~tp;
      done  = go & rp;
    end
    start = 1'b0;
    done  = '0;
    repeat (2) begin
      @(negedge clk);
      check("R2 idle hold", int'(phase), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset phase", int'(phase), 0);
    check("R8 reset bias", int'(bias), 0);
    check("R8 reset permit", int'(go), 0);
    check("R8 reset timeout", int'(tmo), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 no start stays idle", int'(phase), 0);

    for (int ti = 0; ti < 16; ti++)
      for (int ri = 0; ri < 16; ri++)
        run_cycle(NCH'(ti), NCH'(ri));

    // R8: reset in the middle of convert
    @(negedge clk);
    start = 1'b1;
    trig  = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (ACQ + REC) @(negedge clk);
    check("R8 permit before reset", int'(go), 15);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid reset phase", int'(phase), 0);
    check("R8 mid reset bias", int'(bias), 0);
    check("R8 mid reset permit", int'(go), 0);
    check("R8 mid reset timeout", int'(tmo), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule